// File: doc/BRIEF.md
# Host-to-Wishbone Transaction Bridge

This block lets a narrow 16-bit host processor run single 32-bit Wishbone master transactions through a small register window. The host first programs the byte-select lanes, a 32-bit target address as two 16-bit halves and, for stores, 32-bit data as two halves. It then launches the transaction by writing the upper half of either the load-address or the store-address register. The bridge issues a pipelined request: STB is high for one cycle and CYC stays high until the slave acknowledges. Load data lands in the two data halves, and a busy flag in the control word clears on completion.

A store of zero to the control word cancels whatever is in flight. CYC and STB drop at once, the busy flag clears, and an acknowledge that arrives later is discarded. The host can therefore escape from a slave that never answers. The bridge passes the address through without aligning it. The host is responsible for placing data in the correct lanes.

Top module: `hwb_bridge`

## Requirements
- R1: Host offset 0 is the control word. Bits [3:0] hold the byte selects and drive `wb_sel` directly. Bit 15 reads as the busy flag. All other bits read 0.
- R2: A host store to offset 2 starts a load. In the following cycle `wb_cyc`=1, `wb_stb`=1 and `wb_we`=0. `wb_adr` equals {offset 2 value, offset 1 value}.
- R3: A host store to offset 4 starts a store. In the following cycle `wb_cyc`=1, `wb_stb`=1 and `wb_we`=1. `wb_adr` equals {offset 4, offset 3}. `wb_dat_o` equals {offset 6, offset 5}.
- R4: `wb_stb` is high for exactly one cycle per transaction. `wb_cyc` stays high, with address and selects stable, until `wb_ack` is sampled.
- R5: The busy flag (control bit 15) reads 1 from the cycle after the trigger until the edge that samples `wb_ack`. After that edge it reads 0 and `wb_cyc` is 0.
- R6: When a load completes, `wb_dat_i[15:0]` replaces offset 5 and `wb_dat_i[31:16]` replaces offset 6.
- R7: A host store of 0x0000 to offset 0 clears the byte selects. From the next cycle it also forces `wb_cyc`, `wb_stb` and the busy flag to 0.
- R8: A `wb_ack` that arrives after a cancellation leaves offsets 5 and 6 unchanged.
- R9: Address bits [1:0] are presented exactly as written, with no alignment.
- R10: While busy, host stores to offsets 1 through 6 and nonzero stores to offset 0 are ignored. This includes a second trigger.
- R11: After reset all registers read 0, and `wb_cyc`, `wb_stb` and the busy flag are 0.
- R12: Stores to offsets 1, 3, 5 and 6 never start a bus transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host store strobe |
| host_off | input | 3 | Host register offset |
| host_wdata | input | 16 | Host store data |
| host_rdata | output | 16 | Host load data for `host_off` (combinational) |
| wb_cyc | output | 1 | Bus cycle |
| wb_stb | output | 1 | Request strobe |
| wb_we | output | 1 | 1 = store, 0 = load |
| wb_sel | output | 4 | Byte lane selects |
| wb_adr | output | 32 | Target address |
| wb_dat_o | output | 32 | Store data |
| wb_dat_i | input | 32 | Load data from slave |
| wb_ack | input | 1 | Slave acknowledge |

## Verification
Some rules hold on every cycle, and the assertions check those. STB only ever appears inside CYC and never lasts two cycles. Address and selects hold still across an open cycle. A rising CYC always traces back to an upper-address trigger. A cancellation or a sampled acknowledge empties the bus in the next cycle. The bench scenarios cover what needs a value or a history: the load data landing in the right halves, a late acknowledge leaving the data untouched, and stores made while busy having no visible effect.

// File: rtl/hwb_pkg.sv
package hwb_pkg;
    localparam int HOST_W = 16;
    localparam int BUS_W  = 32;
    localparam int SEL_W  = BUS_W / 8;
    localparam int OFF_W  = 3;

    typedef enum logic [OFF_W-1:0] {
        OFF_CTRL  = 3'd0,
        OFF_RA_LO = 3'd1,
        OFF_RA_HI = 3'd2,
        OFF_WA_LO = 3'd3,
        OFF_WA_HI = 3'd4,
        OFF_D_LO  = 3'd5,
        OFF_D_HI  = 3'd6
    } hoff_e;

    localparam int BUSY_BIT = HOST_W - 1;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [BUS_W-1:0] ra;
        logic [BUS_W-1:0] wa;
        logic [BUS_W-1:0] dat;
    } hregs_t;

    function automatic logic [HOST_W-1:0] ctrl_word(logic busy, logic [SEL_W-1:0] s);
        logic [HOST_W-1:0] w;
        w = '0;
        w[BUSY_BIT] = busy;
        w[SEL_W-1:0] = s;
        return w;
    endfunction
endpackage

// File: rtl/hwb_regs.sv
module hwb_regs
    import hwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [HOST_W-1:0] wr_data,
    input  logic              lock,
    input  logic              cap,
    input  logic [BUS_W-1:0]  cap_data,
    output hregs_t            regs
);
    logic zero_ctrl;
    assign zero_ctrl = (wr_data == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else begin
            if (cap) begin
                regs.dat <= cap_data;
            end
            if (wr_en && hoff_e'(wr_off) == OFF_CTRL && (!lock || zero_ctrl)) begin
                regs.sel <= wr_data[SEL_W-1:0];
            end
            if (wr_en && !lock) begin
                case (hoff_e'(wr_off))
                    OFF_RA_LO: regs.ra[HOST_W-1:0]     <= wr_data;
                    OFF_RA_HI: regs.ra[BUS_W-1:HOST_W] <= wr_data;
                    OFF_WA_LO: regs.wa[HOST_W-1:0]     <= wr_data;
                    OFF_WA_HI: regs.wa[BUS_W-1:HOST_W] <= wr_data;
                    OFF_D_LO:  regs.dat[HOST_W-1:0]    <= wr_data;
                    OFF_D_HI:  regs.dat[BUS_W-1:HOST_W] <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    // R10: data halves only move on capture while locked
    assert_locked_data_R10: assert property (@(posedge clk) disable iff (rst)
        (lock && !cap) |=> $stable(regs.dat));
endmodule

// File: rtl/hwb_seq.sv
module hwb_seq (
    input  logic clk,
    input  logic rst,
    input  logic trig_rd,
    input  logic trig_wr,
    input  logic abort,
    input  logic ack,
    output logic busy,
    output logic cyc,
    output logic stb,
    output logic we,
    output logic cap
);
    assign cap = cyc && ack && !we && !abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cyc  <= 1'b0;
            stb  <= 1'b0;
            we   <= 1'b0;
        end else if (abort) begin
            busy <= 1'b0;
            cyc  <= 1'b0;
            stb  <= 1'b0;
        end else if (!busy && (trig_rd || trig_wr)) begin
            busy <= 1'b1;
            cyc  <= 1'b1;
            stb  <= 1'b1;
            we   <= trig_wr;
        end else begin
            stb <= 1'b0;
            if (cyc && ack) begin
                cyc  <= 1'b0;
                busy <= 1'b0;
            end
        end
    end

    assert_stb_in_cyc_R4: assert property (@(posedge clk) disable iff (rst)
        stb |-> cyc);
    assert_stb_single_R4: assert property (@(posedge clk) disable iff (rst)
        stb |=> !stb);
    assert_abort_drop_R7: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!cyc && !stb && !busy));
    assert_ack_done_R5: assert property (@(posedge clk) disable iff (rst)
        (cyc && ack) |=> (!busy && !cyc));
endmodule

// File: rtl/hwb_bridge.sv
module hwb_bridge
    import hwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [OFF_W-1:0]  host_off,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata,
    output logic              wb_cyc,
    output logic              wb_stb,
    output logic              wb_we,
    output logic [SEL_W-1:0]  wb_sel,
    output logic [BUS_W-1:0]  wb_adr,
    output logic [BUS_W-1:0]  wb_dat_o,
    input  logic [BUS_W-1:0]  wb_dat_i,
    input  logic              wb_ack
);
    hregs_t regs;
    logic busy, cap, trig_rd, trig_wr, abort;

    assign trig_rd = host_wr && hoff_e'(host_off) == OFF_RA_HI;
    assign trig_wr = host_wr && hoff_e'(host_off) == OFF_WA_HI;
    assign abort   = host_wr && hoff_e'(host_off) == OFF_CTRL && host_wdata == '0;

    hwb_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(host_wr), .wr_off(host_off),
        .wr_data(host_wdata), .lock(busy), .cap(cap), .cap_data(wb_dat_i),
        .regs(regs)
    );

    hwb_seq u_seq (
        .clk(clk), .rst(rst), .trig_rd(trig_rd), .trig_wr(trig_wr),
        .abort(abort), .ack(wb_ack), .busy(busy), .cyc(wb_cyc),
        .stb(wb_stb), .we(wb_we), .cap(cap)
    );

    assign wb_sel   = regs.sel;
    assign wb_adr   = wb_we ? regs.wa : regs.ra;
    assign wb_dat_o = regs.dat;

    always_comb begin
        case (hoff_e'(host_off))
            OFF_CTRL:  host_rdata = ctrl_word(busy, regs.sel);
            OFF_RA_LO: host_rdata = regs.ra[HOST_W-1:0];
            OFF_RA_HI: host_rdata = regs.ra[BUS_W-1:HOST_W];
            OFF_WA_LO: host_rdata = regs.wa[HOST_W-1:0];
            OFF_WA_HI: host_rdata = regs.wa[BUS_W-1:HOST_W];
            OFF_D_LO:  host_rdata = regs.dat[HOST_W-1:0];
            OFF_D_HI:  host_rdata = regs.dat[BUS_W-1:HOST_W];
            default:   host_rdata = '0;
        endcase
    end

    // R2/R3/R12: a bus cycle only opens after an upper-address store
    assert_cyc_from_trigger_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(wb_cyc) |-> $past(trig_rd || trig_wr));
    assert_hold_request_R4: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc && !abort) |=> ($stable(wb_sel) && $stable(wb_adr)));
endmodule

// File: tb/sim_hwb_bridge.sv
module sim_hwb_bridge;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [2:0]  host_off = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        wb_cyc, wb_stb, wb_we;
    logic [3:0]  wb_sel;
    logic [31:0] wb_adr, wb_dat_o;
    logic [31:0] wb_dat_i = '0;
    logic        wb_ack = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    hwb_bridge u0 (.*);

    typedef struct packed {
        logic        wr;
        logic [3:0]  sel;
        logic [31:0] adr;
        logic [31:0] dat;
        logic [3:0]  lat;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1'b0, 4'hF, 32'h1000_0000, 32'hDEAD_BEEF, 4'd0},
        '{1'b1, 4'hF, 32'h2000_0004, 32'h1234_5678, 4'd2},
        '{1'b0, 4'h3, 32'h3000_0002, 32'h0000_A5A5, 4'd1},
        '{1'b1, 4'hC, 32'h4000_0002, 32'hCAFE_0000, 4'd3},
        '{1'b0, 4'h2, 32'h5000_0001, 32'h0000_7700, 4'd0},
        '{1'b1, 4'h8, 32'h6000_0003, 32'h9900_9900, 4'd4}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwr(logic [2:0] off, logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_off = off; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hrd(logic [2:0] off, output logic [15:0] d);
        host_off = off;
        #1;
        d = host_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL R4 watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 cyc", {31'd0, wb_cyc}, 0);
        chk("R11 stb", {31'd0, wb_stb}, 0);
        for (int k = 0; k < 7; k++) begin
            hrd(3'(k), r);
            chk("R11 regs", {16'd0, r}, 0);
        end

        // main vector walk: R1 R2 R3 R5 R6 R9
        foreach (VEC[i]) begin
            hwr(3'd0, {12'd0, VEC[i].sel});
            chk("R1 sel", {28'd0, wb_sel}, {28'd0, VEC[i].sel});
            if (VEC[i].wr) begin
                hwr(3'd5, VEC[i].dat[15:0]);
                hwr(3'd6, VEC[i].dat[31:16]);
                hwr(3'd3, VEC[i].adr[15:0]);
                chk("R12 no start", {31'd0, wb_cyc}, 0);
                hwr(3'd4, VEC[i].adr[31:16]);
                chk("R3 we", {31'd0, wb_we}, 1);
                chk("R3 dat_o", wb_dat_o, VEC[i].dat);
            end else begin
                hwr(3'd1, VEC[i].adr[15:0]);
                chk("R12 no start", {31'd0, wb_cyc}, 0);
                hwr(3'd2, VEC[i].adr[31:16]);
                chk("R2 we", {31'd0, wb_we}, 0);
            end
            chk("R2 cyc", {31'd0, wb_cyc}, 1);
            chk("R2 stb", {31'd0, wb_stb}, 1);
            chk("R9 adr", wb_adr, VEC[i].adr);
            hrd(3'd0, r);
            chk("R5 busy", {16'd0, r}, {16'd0, 1'b1, 11'd0, VEC[i].sel});
            for (int w = 0; w < int'(VEC[i].lat); w++) begin
                @(negedge clk);
                chk("R4 stb low", {31'd0, wb_stb}, 0);
                chk("R4 cyc held", {31'd0, wb_cyc}, 1);
            end
            wb_ack = 1'b1;
            wb_dat_i = VEC[i].wr ? 32'hFFFF_FFFF : VEC[i].dat;
            @(negedge clk);
            wb_ack = 1'b0;
            chk("R5 cyc done", {31'd0, wb_cyc}, 0);
            hrd(3'd0, r);
            chk("R5 busy clear", {16'd0, r[15], 15'd0}, 0);
            hrd(3'd5, r);
            chk("R6 lo", {16'd0, r}, {16'd0, VEC[i].dat[15:0]});
            hrd(3'd6, r);
            chk("R6 hi", {16'd0, r}, {16'd0, VEC[i].dat[31:16]});
        end

        // R10: stores while busy are ignored
        hwr(3'd0, 16'h000F);
        hwr(3'd5, 16'h1111);
        hwr(3'd1, 16'h0040);
        hwr(3'd2, 16'h7000);
        hwr(3'd4, 16'hAAAA);
        chk("R10 retrigger", {31'd0, wb_stb}, 0);
        chk("R10 we", {31'd0, wb_we}, 0);
        hwr(3'd1, 16'h0BAD);
        hwr(3'd5, 16'h2222);
        hwr(3'd0, 16'h0001);
        chk("R10 adr", wb_adr, 32'h7000_0040);
        chk("R10 sel", {28'd0, wb_sel}, 32'hF);
        hrd(3'd5, r);
        chk("R10 data", {16'd0, r}, 32'h1111);

        // R7 abort, then R8 late ack discarded
        hwr(3'd0, 16'h0000);
        chk("R7 cyc", {31'd0, wb_cyc}, 0);
        chk("R7 stb", {31'd0, wb_stb}, 0);
        hrd(3'd0, r);
        chk("R7 ctrl", {16'd0, r}, 0);
        wb_ack = 1'b1; wb_dat_i = 32'h5555_6666;
        @(negedge clk);
        wb_ack = 1'b0;
        hrd(3'd5, r);
        chk("R8 lo", {16'd0, r}, 32'h1111);
        hrd(3'd6, r);
        chk("R8 hi", {16'd0, r}, {16'd0, VEC[5].dat[31:16]});

        // R12: low-half and data stores do not start a cycle
        hwr(3'd3, 16'h0010);
        hwr(3'd6, 16'h0020);
        chk("R12 idle", {31'd0, wb_cyc}, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule